// File: doc/BRIEF.md
# Strobe/Ready Handshake Port Channel

This block is one 8-bit parallel port channel that sits between a CPU access path and a peripheral. The peripheral talks to it with a strobe input and a ready output. The CPU talks to it with a read pulse, a write window and an active-low interrupt line. The channel moves bytes in one of three directions:

- **Input mode:** the peripheral hands a byte in.
- **Output mode:** the CPU hands a byte out.
- **Bidirectional mode:** a second strobe/ready pair is added. The first pair runs the inbound flow, the second pair runs the outbound flow, and both share the one interrupt line.

A status pair tells the CPU which strobe raised the interrupt.

All peripheral and CPU strobes are asynchronous. Each one passes through a two-flop synchroniser, and its rising and falling edges become single-cycle pulses. The handshake is sequenced on those pulses. A leading strobe edge drops ready. A trailing strobe edge latches data and raises a pending flag. The start of a CPU access clears the pending flag, and the end of the access raises ready. After reset, ready is low, so the CPU performs one read with no data behind it to raise ready before the first inbound transfer.

Top module: `hs_port_chan`

## Requirements
- R1: While `rst_n` is low, `prdy_a_o` and `prdy_b_o` are 0, `int_n_o` is 1, and `stat_o`, `cpu_rdata_o` and `pdata_o` are all zero.
- R2: In input mode (`mode_i` = 0), a rising edge on `pstb_a_i` drives `prdy_a_o` low.
- R3: In input mode, a falling edge on `pstb_a_i` loads `pdata_i` into `cpu_rdata_o` and sets `stat_o[0]`.
- R4: In input mode, the rising edge of `cpu_rd_i` clears `stat_o[0]` and the falling edge raises `prdy_a_o`. This holds with nothing pending as well, so one read after reset raises ready.
- R5: In output mode (`mode_i` = 1), a rising edge on `pstb_a_i` drives `prdy_a_o` low and its falling edge sets `stat_o[0]`. `cpu_rdata_o` does not change.
- R6: In output mode, the rising edge of `cpu_wr_i` clears `stat_o[0]`. The falling edge puts the `cpu_wdata_i` value held during the window onto `pdata_o` and raises `prdy_a_o`.
- R7: In bidirectional mode (`mode_i` = 2):
  - `pstb_a_i`, `prdy_a_o`, reads and `stat_o[0]` follow R2 to R4.
  - `pstb_b_i`, `prdy_b_o`, writes and `stat_o[1]` follow R5 and R6.
  - Outside bidirectional mode, `stat_o[1]` and `prdy_b_o` are 0.
- R8: `int_n_o` is 0 exactly when `int_en_i` is 1 and a bit of `stat_o` is set. With `int_en_i` at 0, `stat_o` still shows the pending cause.
- R9: When a strobe trailing edge and a CPU access start reach the sequencer in the same cycle, the pending flag ends up set. When a strobe leading edge and a CPU access end coincide, ready ends up low.
- R10: With `mode_i` = 3, strobes, reads and writes change none of `prdy_a_o`, `prdy_b_o`, `stat_o`, `cpu_rdata_o` or `pdata_o`.
- R11: An input change made between two clock edges shows at the outputs after the third rising edge that follows it, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low clear |
| mode_i | input | 2 | 0 input, 1 output, 2 bidirectional, 3 idle |
| int_en_i | input | 1 | Interrupt enable |
| pstb_a_i | input | 1 | Peripheral strobe, first pair (active high pulse) |
| prdy_a_o | output | 1 | Ready, first pair |
| pstb_b_i | input | 1 | Peripheral strobe, second pair (bidirectional only) |
| prdy_b_o | output | 1 | Ready, second pair |
| pdata_i | input | 8 | Peripheral data into the channel |
| pdata_o | output | 8 | Output data latch toward the peripheral |
| cpu_rd_i | input | 1 | CPU read pulse |
| cpu_wr_i | input | 1 | CPU write window (high during window) |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | Input buffer toward the CPU |
| stat_o | output | 2 | Pending cause: bit0 first strobe, bit1 second strobe |
| int_n_o | output | 1 | Active-low interrupt |

## Verification
Two functions can land on the sequencer in the same cycle. The first pair is a peripheral strobe trailing edge, which raises pending, and the CPU read start, which clears it. The second pair is a strobe leading edge and the read end, which pull ready in opposite directions. Both coincidences are provoked by toggling the two asynchronous inputs at the same falling clock edge. Since every input passes through an identical synchroniser, the resulting pulses meet in one cycle. The outcome is judged at the ports: a set pending flag with the new byte, and a low ready line.

// File: rtl/hs_port_pkg.sv
package hs_port_pkg;

  typedef enum logic [1:0] {
    HS_MODE_IN   = 2'd0,
    HS_MODE_OUT  = 2'd1,
    HS_MODE_BIDI = 2'd2,
    HS_MODE_OFF  = 2'd3
  } hs_mode_e;

  typedef struct packed {
    logic rise;
    logic fall;
  } hs_edge_t;

  localparam int unsigned HS_NUM_ASYNC = 4;
  localparam int unsigned HS_IDX_STB_A = 0;
  localparam int unsigned HS_IDX_STB_B = 1;
  localparam int unsigned HS_IDX_RD    = 2;
  localparam int unsigned HS_IDX_WR    = 3;

endpackage

// File: rtl/hs_sync_edge.sv
module hs_sync_edge
  import hs_port_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     async_i,
  output hs_edge_t edge_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) sh_q[i] <= sh_q[i-1];
      last_q <= sh_q[LAST];
    end
  end

  assign edge_o.rise = sh_q[LAST] & ~last_q;
  assign edge_o.fall = ~sh_q[LAST] & last_q;

  // R11
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o.rise |=> !edge_o.rise);
  // R11
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o.fall |=> !edge_o.fall);

endmodule

// File: rtl/hs_flag_seq.sv
module hs_flag_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic stb_rise_i,
  input  logic stb_fall_i,
  input  logic cpu_start_i,
  input  logic cpu_end_i,
  output logic rdy_o,
  output logic pend_o
);

  logic rdy_q, rdy_d;
  logic pend_q, pend_d;

  always_comb begin
    rdy_d  = rdy_q;
    pend_d = pend_q;
    if (cpu_end_i)   rdy_d  = 1'b1;
    if (stb_rise_i)  rdy_d  = 1'b0;   // peripheral leading edge has priority
    if (cpu_start_i) pend_d = 1'b0;
    if (stb_fall_i)  pend_d = 1'b1;   // a fresh event is never lost
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      pend_q <= 1'b0;
    end else if (act_i) begin
      rdy_q  <= rdy_d;
      pend_q <= pend_d;
    end
  end

  assign rdy_o  = rdy_q;
  assign pend_o = pend_q;

  // R2
  rdy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_i && stb_rise_i |=> !rdy_o);
  // R4
  rdy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_i && cpu_end_i && !stb_rise_i |=> rdy_o);
  // R9
  pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_i && stb_fall_i |=> pend_o);
  // R4
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_i && cpu_start_i && !stb_fall_i |=> !pend_o);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act_i |=> $stable(rdy_o) && $stable(pend_o));

endmodule

// File: rtl/hs_port_chan.sv
module hs_port_chan
  import hs_port_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode_i,
  input  logic              int_en_i,
  input  logic              pstb_a_i,
  output logic              prdy_a_o,
  input  logic              pstb_b_i,
  output logic              prdy_b_o,
  input  logic [DATA_W-1:0] pdata_i,
  output logic [DATA_W-1:0] pdata_o,
  input  logic              cpu_rd_i,
  input  logic              cpu_wr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic [1:0]        stat_o,
  output logic              int_n_o
);

  hs_mode_e mode;
  assign mode = hs_mode_e'(mode_i);

  logic [HS_NUM_ASYNC-1:0] async_v;
  hs_edge_t                ev [HS_NUM_ASYNC];

  assign async_v[HS_IDX_STB_A] = pstb_a_i;
  assign async_v[HS_IDX_STB_B] = pstb_b_i;
  assign async_v[HS_IDX_RD]    = cpu_rd_i;
  assign async_v[HS_IDX_WR]    = cpu_wr_i;

  for (genvar g = 0; g < HS_NUM_ASYNC; g++) begin : g_sync
    hs_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .async_i(async_v[g]),
      .edge_o (ev[g])
    );
  end

  // Routing of strobe pairs onto the inbound and outbound sequencers
  logic     in_act, out_act;
  hs_edge_t out_stb;
  assign in_act  = (mode == HS_MODE_IN)  || (mode == HS_MODE_BIDI);
  assign out_act = (mode == HS_MODE_OUT) || (mode == HS_MODE_BIDI);
  assign out_stb = (mode == HS_MODE_BIDI) ? ev[HS_IDX_STB_B] : ev[HS_IDX_STB_A];

  logic in_rdy, in_pend, out_rdy, out_pend;

  hs_flag_seq u_in_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_i      (in_act),
    .stb_rise_i (ev[HS_IDX_STB_A].rise),
    .stb_fall_i (ev[HS_IDX_STB_A].fall),
    .cpu_start_i(ev[HS_IDX_RD].rise),
    .cpu_end_i  (ev[HS_IDX_RD].fall),
    .rdy_o      (in_rdy),
    .pend_o     (in_pend)
  );

  hs_flag_seq u_out_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_i      (out_act),
    .stb_rise_i (out_stb.rise),
    .stb_fall_i (out_stb.fall),
    .cpu_start_i(ev[HS_IDX_WR].rise),
    .cpu_end_i  (ev[HS_IDX_WR].fall),
    .rdy_o      (out_rdy),
    .pend_o     (out_pend)
  );

  // Data path: inbound buffer, write-window holding register, output latch
  logic [DATA_W-1:0] in_buf_q, in_buf_d;
  logic [DATA_W-1:0] wd_hold_q, wd_hold_d;
  logic [DATA_W-1:0] out_q, out_d;
  logic              win_q, win_d;
  logic              in_buf_en, wd_hold_en, out_en, win_en;

  always_comb begin
    in_buf_en  = in_act && ev[HS_IDX_STB_A].fall;
    in_buf_d   = pdata_i;
    win_en     = out_act && (ev[HS_IDX_WR].rise || ev[HS_IDX_WR].fall);
    win_d      = ev[HS_IDX_WR].rise;
    wd_hold_en = out_act && (win_q || ev[HS_IDX_WR].rise);
    wd_hold_d  = cpu_wdata_i;
    out_en     = out_act && ev[HS_IDX_WR].fall;
    out_d      = wd_hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_buf_q  <= '0;
      wd_hold_q <= '0;
      out_q     <= '0;
      win_q     <= 1'b0;
    end else begin
      if (in_buf_en)  in_buf_q  <= in_buf_d;
      if (wd_hold_en) wd_hold_q <= wd_hold_d;
      if (out_en)     out_q     <= out_d;
      if (win_en)     win_q     <= win_d;
    end
  end

  // Port-side mapping
  assign prdy_a_o    = (mode == HS_MODE_OUT) ? out_rdy : in_rdy;
  assign prdy_b_o    = (mode == HS_MODE_BIDI) && out_rdy;
  assign stat_o[0]   = (mode == HS_MODE_OUT) ? out_pend : in_pend;
  assign stat_o[1]   = (mode == HS_MODE_BIDI) && out_pend;
  assign int_n_o     = ~(int_en_i && (stat_o != 2'b00));
  assign cpu_rdata_o = in_buf_q;
  assign pdata_o     = out_q;

  // R8
  int_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en_i |-> int_n_o);
  // R7
  bidi_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != HS_MODE_BIDI) |-> (!stat_o[1] && !prdy_b_o));
  // R3
  in_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_act && ev[HS_IDX_STB_A].fall |=> cpu_rdata_o == $past(pdata_i));
  // R10
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == HS_MODE_OFF) |=> $stable(cpu_rdata_o) && $stable(pdata_o));

endmodule

// File: tb/hs_port_chan_tb_top.sv
module hs_port_chan_tb_top;

  typedef struct packed {
    logic [1:0] op;     // 0 strobe A, 1 strobe B, 2 read, 3 write
    logic [1:0] mode;
    logic [7:0] din;
    logic       ra;
    logic       rb;
    logic       intn;
    logic [1:0] st;
    logic [7:0] rdat;
    logic [7:0] pout;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{2'd2, 2'd0, 8'h00, 1'b1, 1'b0, 1'b1, 2'b00, 8'h00, 8'h00},
    '{2'd0, 2'd0, 8'h5A, 1'b0, 1'b0, 1'b0, 2'b01, 8'h5A, 8'h00},
    '{2'd2, 2'd0, 8'h00, 1'b1, 1'b0, 1'b1, 2'b00, 8'h5A, 8'h00},
    '{2'd0, 2'd0, 8'hC3, 1'b0, 1'b0, 1'b0, 2'b01, 8'hC3, 8'h00},
    '{2'd2, 2'd0, 8'h00, 1'b1, 1'b0, 1'b1, 2'b00, 8'hC3, 8'h00},
    '{2'd0, 2'd1, 8'h11, 1'b0, 1'b0, 1'b0, 2'b01, 8'hC3, 8'h00},
    '{2'd3, 2'd1, 8'h96, 1'b1, 1'b0, 1'b1, 2'b00, 8'hC3, 8'h96},
    '{2'd0, 2'd1, 8'h22, 1'b0, 1'b0, 1'b0, 2'b01, 8'hC3, 8'h96},
    '{2'd3, 2'd1, 8'h3C, 1'b1, 1'b0, 1'b1, 2'b00, 8'hC3, 8'h3C},
    '{2'd1, 2'd2, 8'h00, 1'b1, 1'b0, 1'b0, 2'b10, 8'hC3, 8'h3C},
    '{2'd0, 2'd2, 8'hE7, 1'b0, 1'b0, 1'b0, 2'b11, 8'hE7, 8'h3C},
    '{2'd2, 2'd2, 8'h00, 1'b1, 1'b0, 1'b0, 2'b10, 8'hE7, 8'h3C},
    '{2'd3, 2'd2, 8'h81, 1'b1, 1'b1, 1'b1, 2'b00, 8'hE7, 8'h81},
    '{2'd0, 2'd3, 8'h00, 1'b1, 1'b0, 1'b1, 2'b00, 8'hE7, 8'h81},
    '{2'd1, 2'd3, 8'h00, 1'b1, 1'b0, 1'b1, 2'b00, 8'hE7, 8'h81},
    '{2'd3, 2'd3, 8'h00, 1'b1, 1'b0, 1'b1, 2'b00, 8'hE7, 8'h81},
    '{2'd2, 2'd3, 8'h00, 1'b1, 1'b0, 1'b1, 2'b00, 8'hE7, 8'h81}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode;
  logic       int_en;
  logic       stb_a, stb_b, rd, wr;
  logic [7:0] pdata_in, wdata;
  logic       rdy_a, rdy_b, int_n;
  logic [7:0] pdata_out, rdata;
  logic [1:0] stat;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  hs_port_chan dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode),
    .int_en_i   (int_en),
    .pstb_a_i   (stb_a),
    .prdy_a_o   (rdy_a),
    .pstb_b_i   (stb_b),
    .prdy_b_o   (rdy_b),
    .pdata_i    (pdata_in),
    .pdata_o    (pdata_out),
    .cpu_rd_i   (rd),
    .cpu_wr_i   (wr),
    .cpu_wdata_i(wdata),
    .cpu_rdata_o(rdata),
    .stat_o     (stat),
    .int_n_o    (int_n)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input bit use_b, input logic [7:0] d);
    pdata_in = d;
    if (use_b) stb_b = 1'b1; else stb_a = 1'b1;
    wait_n(4);
    if (use_b) stb_b = 1'b0; else stb_a = 1'b0;
    wait_n(4);
  endtask

  task automatic cpu_read();
    rd = 1'b1; wait_n(4);
    rd = 1'b0; wait_n(4);
  endtask

  task automatic cpu_write(input logic [7:0] d);
    wdata = d;
    wr = 1'b1; wait_n(4);
    wr = 1'b0; wait_n(4);
    wdata = 8'h00;
  endtask

  task automatic check_reset_state();
    chk("R1", "rdy_a", rdy_a, 0);
    chk("R1", "rdy_b", rdy_b, 0);
    chk("R1", "int_n", int_n, 1);
    chk("R1", "stat", stat, 0);
    chk("R1", "rdata", rdata, 0);
    chk("R1", "pdata_o", pdata_out, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 2'd0; int_en = 1'b1;
    stb_a = 1'b0; stb_b = 1'b0; rd = 1'b0; wr = 1'b0;
    pdata_in = 8'h00; wdata = 8'h00;
    wait_n(3);
    check_reset_state();                       // R1
    rst_n = 1'b1;
    wait_n(2);

    // Table walk: R3 R4 (input), R5 R6 (output), R7 (bidirectional), R10 (idle)
    for (int i = 0; i < NV; i++) begin
      string req;
      mode = VECS[i].mode;
      wait_n(1);
      case (VECS[i].op)
        2'd0: strobe(1'b0, VECS[i].din);
        2'd1: strobe(1'b1, VECS[i].din);
        2'd2: cpu_read();
        default: cpu_write(VECS[i].din);
      endcase
      case (VECS[i].mode)
        2'd0: req = "R3/R4";
        2'd1: req = "R5/R6";
        2'd2: req = "R7";
        default: req = "R10";
      endcase
      chk(req, $sformatf("vec%0d rdy_a", i), rdy_a, VECS[i].ra);
      chk(req, $sformatf("vec%0d rdy_b", i), rdy_b, VECS[i].rb);
      chk(req, $sformatf("vec%0d int_n", i), int_n, VECS[i].intn);
      chk(req, $sformatf("vec%0d stat", i), stat, VECS[i].st);
      chk(req, $sformatf("vec%0d rdata", i), rdata, VECS[i].rdat);
      chk(req, $sformatf("vec%0d pdata_o", i), pdata_out, VECS[i].pout);
    end

    // R11 and R2: latency of a strobe leading edge to ready low
    mode = 2'd0;
    wait_n(2);
    pdata_in = 8'h24;
    stb_a = 1'b1;
    wait_n(2);
    chk("R11", "rdy_a after two edges", rdy_a, 1);
    wait_n(1);
    chk("R2", "rdy_a after three edges", rdy_a, 0);
    wait_n(2);
    stb_a = 1'b0;
    wait_n(4);
    chk("R3", "rdata after trailing edge", rdata, 8'h24);
    chk("R3", "stat after trailing edge", stat, 2'b01);
    cpu_read();
    chk("R4", "rdy_a after read", rdy_a, 1);

    // R8: pending visible while interrupt disabled
    int_en = 1'b0;
    strobe(1'b0, 8'h99);
    chk("R8", "stat while disabled", stat, 2'b01);
    chk("R8", "int_n while disabled", int_n, 1);
    int_en = 1'b1;
    #1;
    chk("R8", "int_n after enable", int_n, 0);
    cpu_read();

    // R9: trailing strobe edge meets read start
    stb_a = 1'b1;
    wait_n(4);
    pdata_in = 8'h42;
    stb_a = 1'b0;
    rd = 1'b1;
    wait_n(4);
    chk("R9", "stat set wins", stat, 2'b01);
    chk("R9", "int_n set wins", int_n, 0);
    chk("R9", "rdata on coincidence", rdata, 8'h42);
    // R9: leading strobe edge meets read end
    pdata_in = 8'h17;
    rd = 1'b0;
    stb_a = 1'b1;
    wait_n(4);
    chk("R9", "rdy_a clear wins", rdy_a, 0);
    stb_a = 1'b0;
    wait_n(4);
    chk("R3", "rdata second byte", rdata, 8'h17);
    cpu_read();
    chk("R4", "rdy_a final read", rdy_a, 1);
    chk("R4", "stat final read", stat, 2'b00);

    // R1: clear in the middle of a transfer
    strobe(1'b0, 8'h5F);
    rst_n = 1'b0;
    #1;
    check_reset_state();
    wait_n(2);
    rst_n = 1'b1;
    wait_n(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule